// File: doc/BRIEF.md
# Two-Stage Interrupt Flag Aggregator

This block collects a vector of per-source interrupt conditions into one request line and then feeds that line through a second stage that keeps a pending bit and a controller enable. The first stage holds one sticky flag per source. Hardware conditions set the flags. Software can load the whole flag register, set bits through a set strobe or clear bits through a clear strobe. Each flag is masked by its own enable bit, and the masked flags are ORed into the request line.

The second stage samples the request line into a pending bit. Software can also set or clear that bit directly. The core acknowledges the request, and the acknowledge clears the pending bit. The pending bit is gated by a controller enable, which has its own set and clear strobes, to form the request sent to the core. All writes arrive as single-cycle strobes that share one write-data bus.

Top module: `irq_flag_agg`

## Requirements
- R1: While rst_ni is low, and from the moment it falls, all of flags_o, en_o, pend_o, ctl_en_o, irq_line_o and core_req_o read 0.
- R2: A 1 on hw_cond_i[i] sets flags_o[i] at the next rising clock edge. The flag stays at 1 after the condition goes away.
- R3: With flag_set_wr_i high, every bit where wdata_i is 1 sets the matching flag. Bits where wdata_i is 0 leave their flags unchanged. When the set and clear strobes are both high in one cycle, the set wins.
- R4: With flag_clr_wr_i high, every bit where wdata_i is 1 clears the matching flag. Bits where wdata_i is 0 leave their flags unchanged.
- R5: A hardware condition on a bit beats a clear strobe or a direct flag write to that bit in the same cycle, so the flag ends at 1.
- R6: flag_wr_i loads wdata_i into the flag register. en_wr_i loads wdata_i into the enable register. Both take effect at the next edge.
- R7: irq_line_o is 1 exactly when some bit is 1 in both flags_o and en_o.
- R8: A 1 on irq_line_o, or a set_pend_i strobe, sets pend_o at the next edge. clr_pend_i clears pend_o only when the line is low. A high line overrides the clear.
- R9: ack_i clears pend_o at the next edge and overrides every set source. If the line is still high, pend_o returns to 1 one edge later.
- R10: set_en_i sets ctl_en_o and clr_en_i clears it. When both strobes are high together, the set wins.
- R11: core_req_o is 1 exactly when pend_o and ctl_en_o are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_cond_i | input | N_SRC | Hardware interrupt conditions, one per source |
| wdata_i | input | N_SRC | Write data shared by the flag, set, clear and enable strobes |
| flag_wr_i | input | 1 | Load the flag register from wdata_i |
| flag_set_wr_i | input | 1 | Set the flags where wdata_i is 1 |
| flag_clr_wr_i | input | 1 | Clear the flags where wdata_i is 1 |
| en_wr_i | input | 1 | Load the per-source enables from wdata_i |
| set_pend_i | input | 1 | Set the pending bit |
| clr_pend_i | input | 1 | Clear the pending bit |
| set_en_i | input | 1 | Set the controller enable |
| clr_en_i | input | 1 | Clear the controller enable |
| ack_i | input | 1 | Acknowledge from the core; clears the pending bit |
| flags_o | output | N_SRC | Flag readback |
| en_o | output | N_SRC | Per-source enable readback |
| irq_line_o | output | 1 | Combined request line |
| pend_o | output | 1 | Pending bit |
| ctl_en_o | output | 1 | Controller enable |
| core_req_o | output | 1 | Request to the core |

## Verification
The collisions that matter are a hardware condition arriving in the same cycle as a clear or direct write of its flag, and an acknowledge or clear-pending strobe arriving while the request line is still high. The bench provokes both from its vector table. It drives the condition together with the clearing strobe on one bit and expects the flag to survive. It then acknowledges or clears the pending bit with the line held high, and checks that the acknowledge empties the pending bit for exactly one edge, while a clear-pending strobe loses to the line. The set-against-clear ties on the flags and on the controller enable are judged the same way, by reading the register after the edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef struct packed {
    logic set_pend;
    logic clr_pend;
    logic set_en;
    logic clr_en;
    logic ack;
  } ctl_cmd_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_cond_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             flag_wr_i,
  input  logic             flag_set_wr_i,
  input  logic             flag_clr_wr_i,
  input  logic             en_wr_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] en_o
);
  logic [N_SRC-1:0] flag_q, flag_d, en_q;
  logic [N_SRC-1:0] set_m, clr_m;

  assign set_m = flag_set_wr_i ? wdata_i : '0;
  assign clr_m = flag_clr_wr_i ? wdata_i : '0;

  // hardware set has top priority, then direct load, then set over clear
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign flag_d[i] = hw_cond_i[i] |
                       (flag_wr_i ? wdata_i[i] : (set_m[i] | (flag_q[i] & ~clr_m[i])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;

  p_hw_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_cond_i != '0) |=> ((flag_q & $past(hw_cond_i)) == $past(hw_cond_i)));

  p_clr_works_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_wr_i && !flag_set_wr_i && !flag_wr_i)
      |=> ((flag_q & $past(wdata_i & ~hw_cond_i)) == '0));

  p_quiet_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_wr_i && !flag_set_wr_i && !flag_clr_wr_i && hw_cond_i == '0) |=> $stable(flag_q));
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0] flags_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             line_o
);
  logic [N_SRC-1:0] qual;
  assign qual   = flags_i & en_i;
  assign line_o = |qual;
endmodule

// File: rtl/irq_pend_stage.sv
module irq_pend_stage
  import irq_agg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     line_i,
  input  ctl_cmd_t cmd_i,
  output logic     pend_o,
  output logic     ctl_en_o,
  output logic     core_req_o
);
  logic pend_q, cen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cen_q  <= 1'b0;
    end else begin
      // ack blanks pending one cycle; a still-high line re-arms it next edge
      if (cmd_i.ack)  pend_q <= 1'b0;
      else            pend_q <= line_i | cmd_i.set_pend | (pend_q & ~cmd_i.clr_pend);
      if (cmd_i.set_en)      cen_q <= 1'b1;
      else if (cmd_i.clr_en) cen_q <= 1'b0;
    end
  end

  assign pend_o     = pend_q;
  assign ctl_en_o   = cen_q;
  assign core_req_o = pend_q & cen_q;

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.ack |=> !pend_q);

  p_line_pends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !cmd_i.ack) |=> pend_q);

  p_en_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.set_en |=> cen_q);

  p_en_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.clr_en && !cmd_i.set_en) |=> !cen_q);
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_cond_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             flag_wr_i,
  input  logic             flag_set_wr_i,
  input  logic             flag_clr_wr_i,
  input  logic             en_wr_i,
  input  logic             set_pend_i,
  input  logic             clr_pend_i,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] en_o,
  output logic             irq_line_o,
  output logic             pend_o,
  output logic             ctl_en_o,
  output logic             core_req_o
);
  ctl_cmd_t cmd;
  logic     line;

  assign cmd = '{set_pend: set_pend_i, clr_pend: clr_pend_i,
                 set_en: set_en_i, clr_en: clr_en_i, ack: ack_i};

  irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i, .rst_ni, .hw_cond_i, .wdata_i, .flag_wr_i, .flag_set_wr_i,
    .flag_clr_wr_i, .en_wr_i, .flags_o, .en_o
  );

  irq_req_merge #(.N_SRC(N_SRC)) u_merge (
    .flags_i(flags_o), .en_i(en_o), .line_o(line)
  );

  irq_pend_stage u_pend (
    .clk_i, .rst_ni, .line_i(line), .cmd_i(cmd),
    .pend_o, .ctl_en_o, .core_req_o
  );

  assign irq_line_o = line;
endmodule

// File: tb/irq_flag_agg_bench.sv
module irq_flag_agg_bench;
  localparam int N = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] hw_cond_i = '0, wdata_i = '0;
  logic flag_wr_i = 0, flag_set_wr_i = 0, flag_clr_wr_i = 0, en_wr_i = 0;
  logic set_pend_i = 0, clr_pend_i = 0, set_en_i = 0, clr_en_i = 0, ack_i = 0;
  logic [N-1:0] flags_o, en_o;
  logic irq_line_o, pend_o, ctl_en_o, core_req_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  irq_flag_agg #(.N_SRC(N)) u_irq_flag_agg (.*);

  typedef struct packed {
    logic [31:0] tag;
    logic [15:0] wd, hw;
    logic fw, fs, fc, ew, sp, cp, se, ce, ack;
    logic [15:0] ef, ee;
    logic ep, ec, el, er;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{"R6",  16'h00FF, 16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R2",  16'h0000, 16'h0001, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0001, 16'h00FF, 1'b0,1'b0,1'b1,1'b0},
    '{"R8",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0001, 16'h00FF, 1'b1,1'b0,1'b1,1'b0},
    '{"R11", 16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0001, 16'h00FF, 1'b1,1'b1,1'b1,1'b1},
    '{"R9",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'h0001, 16'h00FF, 1'b0,1'b1,1'b1,1'b0},
    '{"R9",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0001, 16'h00FF, 1'b1,1'b1,1'b1,1'b1},
    '{"R4",  16'h0001, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000, 16'h00FF, 1'b1,1'b1,1'b0,1'b1},
    '{"R8",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h00FF, 1'b0,1'b1,1'b0,1'b0},
    '{"R8",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0000, 16'h00FF, 1'b1,1'b1,1'b0,1'b1},
    '{"R9",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 16'h0000, 16'h00FF, 1'b0,1'b1,1'b0,1'b0},
    '{"R7",  16'h0300, 16'h0000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0300, 16'h00FF, 1'b0,1'b1,1'b0,1'b0},
    '{"R10", 16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 16'h0300, 16'h00FF, 1'b0,1'b1,1'b0,1'b0},
    '{"R10", 16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0300, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R5",  16'h0400, 16'h0400, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0700, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R4",  16'h0100, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0600, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R3",  16'h0000, 16'h0000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0600, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R4",  16'h0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0600, 16'h00FF, 1'b0,1'b0,1'b0,1'b0},
    '{"R6",  16'hA005, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'hA005, 16'h00FF, 1'b0,1'b0,1'b1,1'b0},
    '{"R11", 16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'hA005, 16'h00FF, 1'b1,1'b0,1'b1,1'b0},
    '{"R5",  16'h0000, 16'h8000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h8000, 16'h00FF, 1'b1,1'b0,1'b0,1'b0},
    '{"R7",  16'hFFFF, 16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h8000, 16'hFFFF, 1'b1,1'b0,1'b1,1'b0},
    '{"R8",  16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 16'h8000, 16'hFFFF, 1'b1,1'b0,1'b1,1'b0},
    '{"R3",  16'h0002, 16'h0000, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h8002, 16'hFFFF, 1'b1,1'b0,1'b1,1'b0}
  };

  task automatic check_all(input string tag, input logic [15:0] ef, input logic [15:0] ee,
                           input logic ep, input logic ec, input logic el, input logic er);
    checks++;
    if (flags_o !== ef || en_o !== ee || pend_o !== ep || ctl_en_o !== ec ||
        irq_line_o !== el || core_req_o !== er) begin
      errors++;
      $display("FAIL %s: got flags=%h en=%h pend=%b cen=%b line=%b req=%b, expected flags=%h en=%h pend=%b cen=%b line=%b req=%b",
               tag, flags_o, en_o, pend_o, ctl_en_o, irq_line_o, core_req_o,
               ef, ee, ep, ec, el, er);
    end
  endtask

  task automatic drive(input vec_t v);
    wdata_i = v.wd; hw_cond_i = v.hw;
    flag_wr_i = v.fw; flag_set_wr_i = v.fs; flag_clr_wr_i = v.fc; en_wr_i = v.ew;
    set_pend_i = v.sp; clr_pend_i = v.cp; set_en_i = v.se; clr_en_i = v.ce; ack_i = v.ack;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_all("R1", 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk_i);
      @(negedge clk_i);
      check_all($sformatf("%s row %0d", string'(TBL[i].tag), i),
                TBL[i].ef, TBL[i].ee, TBL[i].ep, TBL[i].ec, TBL[i].el, TBL[i].er);
    end

    // R5: a condition held for several cycles survives a clear every cycle
    idle();
    hw_cond_i = 16'h0010; wdata_i = 16'h0010; flag_clr_wr_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_all("R5 held", 16'h8012, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);

    // R9: ack with the line high, then pending returns one edge later
    idle();
    set_en_i = 1'b1; ack_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check_all("R9 ack", 16'h8012, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
    idle();
    @(posedge clk_i); @(negedge clk_i);
    check_all("R9 rearm", 16'h8012, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1);

    // R1: asynchronous reset mid-run
    #0.5 rst_ni = 1'b0;
    #0.5;
    check_all("R1 async", 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule